// File: doc/BRIEF.md
# SMBus Packet Error Code Engine

This block runs alongside the byte layer of an SMBus/PMBus-style slave and handles the packet error code. It is fed one byte per cycle, qualified by a valid strobe, and single-cycle markers for start, repeated start and stop. From these it keeps a CRC-8 that covers the whole transaction. The CRC includes the address byte sent before a repeated start, the command byte, the second address byte and all data bytes.

The first byte after a start or repeated start is the address byte, and its bit 0 selects the direction of the phase that follows. If the final phase is a write, the last byte before stop is taken as the master's check byte and compared against the CRC of everything before it. If the final phase is a read, the running CRC is the byte the slave must append after its last data byte. At stop the block issues a one-cycle verdict. A command is acted on only when that verdict passes.

Top module: `smb_pec_engine`

## Requirements
- R1: The CRC uses generator 0x07 (x^8+x^2+x+1), processes each byte MSB first, starts from 0x00 and uses no reflection and no final XOR. `pec_o` shows the CRC of all bytes folded so far, one cycle after each byte. For example, the bytes 0x31..0x39 give 0xF4.
- R2: A start marker sets `pec_o` to 0x00 on the next cycle and opens an address phase, even when a transaction is already in progress.
- R3: A repeated start inside a transaction leaves `pec_o` unchanged and opens a new address phase. The next byte is an address byte whose bit 0 selects the phase direction (1 = read, 0 = write).
- R4: Bytes strobed while no transaction is open are ignored: `pec_o` stays unchanged.
- R5: When the final phase is a write with at least two bytes after the address, the verdict passes only if the last byte equals the CRC of all earlier bytes of the transaction.
- R6: A write whose final phase has fewer than two bytes after its address (no trailing check byte) fails. A stop that arrives before the address byte of a phase also fails.
- R7: When the final phase is a read, `pec_o` before stop equals the CRC over both address bytes, the command and the read data. The verdict passes only if at least one data byte followed the read address.
- R8: A stop inside a transaction makes `verdict_valid_o` high for exactly one cycle, the cycle after the stop is sampled. `verdict_pass_o` is valid in that cycle and low otherwise. A stop while idle gives no verdict.
- R9: When markers and a byte arrive in the same cycle, the byte is dropped. Among markers, stop takes priority over start, and start over repeated start.
- R10: After reset `pec_o` is 0x00, both verdict outputs are low and no transaction is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start condition marker |
| rstart_i | input | 1 | Repeated start marker |
| stop_i | input | 1 | Stop condition marker |
| byte_valid_i | input | 1 | Byte strobe |
| byte_i | input | DATA_W | Byte on the bus, from either side |
| pec_o | output | DATA_W | Running CRC; the byte to append on reads |
| verdict_valid_o | output | 1 | One-cycle pulse after stop |
| verdict_pass_o | output | 1 | Transaction check passed |

## Verification
The hardest situations to reach from the ports are the marker collisions, where a byte strobe coincides with a repeated start or stop, or where start and stop arrive together. In these cases the dropped byte leaves no trace unless later behaviour shows it. The bench builds transactions in which folding the colliding byte would change the verdict, or would reopen a transaction that then folds an idle byte, so `pec_o` and the verdict reveal any wrong priority. Alongside this, every command value is swept against several addresses with both a correct check byte and a check byte with one bit flipped.

// File: rtl/smb_pec_pkg.sv
package smb_pec_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;
endpackage

// File: rtl/pec_crc_step.sv
// One full byte of CRC update, unrolled bit by bit, MSB first.
module pec_crc_step #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] POLY = W'(8'h07)
) (
  input  logic [W-1:0] crc_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] stage [0:W];

  assign stage[0] = crc_i;

  for (genvar k = 0; k < W; k++) begin : g_bit
    logic fb;
    assign fb = stage[k][W-1] ^ data_i[W-1-k];
    assign stage[k+1] = {stage[k][W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign crc_o = stage[W];
endmodule

// File: rtl/pec_phase_fsm.sv
module pec_phase_fsm
  import smb_pec_pkg::*;
#(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rstart_i,
  input  logic             stop_i,
  input  logic             byte_valid_i,
  input  logic             addr_rd_i,
  output phase_e           phase_o,
  output logic             rd_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fold_o,
  output logic             open_o,
  output logic             close_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  phase_e           phase_q;
  logic             rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             mark;

  assign mark    = start_i | rstart_i | stop_i;
  assign fold_o  = byte_valid_i & ~mark & (phase_q != PH_IDLE);
  assign open_o  = start_i & ~stop_i;
  assign close_o = stop_i & (phase_q != PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      rd_q    <= 1'b0;
      cnt_q   <= '0;
    end else if (stop_i) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (start_i) begin
      phase_q <= PH_ADDR;
      rd_q    <= 1'b0;
      cnt_q   <= '0;
    end else if (rstart_i && phase_q != PH_IDLE) begin
      phase_q <= PH_ADDR;
      cnt_q   <= '0;
    end else if (fold_o) begin
      if (phase_q == PH_ADDR) begin
        phase_q <= PH_DATA;
        rd_q    <= addr_rd_i;
        cnt_q   <= '0;
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign phase_o = phase_q;
  assign rd_o    = rd_q;
  assign cnt_o   = cnt_q;

  AST_STOP_IDLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> phase_q == PH_IDLE) else $error("stop did not close"); // R8
  AST_ADDR_SETS_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fold_o && phase_q == PH_ADDR) |=> (phase_q == PH_DATA && rd_q == $past(addr_rd_i)))
    else $error("address byte direction lost"); // R3
  AST_RSTART_REOPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rstart_i && !start_i && !stop_i && phase_q != PH_IDLE) |=> phase_q == PH_ADDR)
    else $error("repeated start not honoured"); // R3
endmodule

// File: rtl/smb_pec_engine.sv
module smb_pec_engine
  import smb_pec_pkg::*;
#(
  parameter int unsigned       DATA_W = 8,
  parameter logic [DATA_W-1:0] POLY   = DATA_W'(8'h07),
  parameter logic [DATA_W-1:0] INIT   = '0,
  parameter int unsigned       CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rstart_i,
  input  logic              stop_i,
  input  logic              byte_valid_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic [DATA_W-1:0] pec_o,
  output logic              verdict_valid_o,
  output logic              verdict_pass_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_TWO = CNT_W'(2);

  phase_e            phase;
  logic              rd;
  logic [CNT_W-1:0]  cnt;
  logic              fold, open, close;
  logic [DATA_W-1:0] crc_q, crc_prev_q, last_q, crc_next;
  logic              valid_q, pass_q, pass_d, wr_ok, rd_ok;

  pec_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .rstart_i    (rstart_i),
    .stop_i      (stop_i),
    .byte_valid_i(byte_valid_i),
    .addr_rd_i   (byte_i[0]),
    .phase_o     (phase),
    .rd_o        (rd),
    .cnt_o       (cnt),
    .fold_o      (fold),
    .open_o      (open),
    .close_o     (close)
  );

  pec_crc_step #(.W(DATA_W), .POLY(POLY)) u_step (
    .crc_i (crc_q),
    .data_i(byte_i),
    .crc_o (crc_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q      <= INIT;
      crc_prev_q <= INIT;
      last_q     <= '0;
    end else if (open) begin
      crc_q      <= INIT;
      crc_prev_q <= INIT;
    end else if (fold) begin
      crc_prev_q <= crc_q;
      crc_q      <= crc_next;
      last_q     <= byte_i;
    end
  end

  // Write: trailing byte must match CRC of everything before it.
  assign wr_ok  = !rd && (cnt >= CNT_TWO) && (last_q == crc_prev_q);
  assign rd_ok  = rd && (cnt >= CNT_ONE);
  assign pass_d = close && (phase == PH_DATA) && (wr_ok || rd_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      valid_q <= close;
      pass_q  <= pass_d;
    end
  end

  assign pec_o           = crc_q;
  assign verdict_valid_o = valid_q;
  assign verdict_pass_o  = pass_q;

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i) |=> pec_o == INIT) else $error("start kept crc"); // R2
  AST_RSTART_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rstart_i && !start_i) |=> $stable(pec_o)) else $error("rstart touched crc"); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_IDLE && !start_i) |=> $stable(pec_o)) else $error("idle byte folded"); // R4
  AST_SHORT_WRITE_FAILS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close && !rd && cnt < CNT_TWO) |=> (verdict_valid_o && !verdict_pass_o))
    else $error("short write accepted"); // R6
  AST_VERDICT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_valid_o |=> !verdict_valid_o) else $error("verdict held"); // R8
  AST_PASS_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !verdict_valid_o |-> !verdict_pass_o) else $error("stray pass"); // R8
endmodule

// File: tb/tb_smb_pec_engine.sv
module tb_smb_pec_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       st = 1'b0, rs = 1'b0, sp = 1'b0, bv = 1'b0;
  logic [7:0] bd = '0;
  logic [7:0] pec;
  logic       vv, vp;
  int         n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  smb_pec_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st), .rstart_i(rs), .stop_i(sp),
    .byte_valid_i(bv), .byte_i(bd), .pec_o(pec),
    .verdict_valid_o(vv), .verdict_pass_o(vp)
  );

  function automatic logic [7:0] crc_b(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one cycle starting at a negedge, return at the next negedge.
  task automatic drv(input logic s, input logic r, input logic p, input logic v, input logic [7:0] b);
    st = s; rs = r; sp = p; bv = v; bd = b;
    @(negedge clk);
    st = 0; rs = 0; sp = 0; bv = 0; bd = '0;
  endtask

  task automatic put(input logic [7:0] b); drv(0, 0, 0, 1, b); endtask
  task automatic do_start();               drv(1, 0, 0, 0, 8'h00); endtask
  task automatic do_rstart();              drv(0, 1, 0, 0, 8'h00); endtask

  task automatic stop_expect(input string req, input logic pass);
    drv(0, 0, 1, 0, 8'h00);
    chk(req, {vv, vp}, {1'b1, pass});
    @(negedge clk);
    chk("R8 pulse width", vv, 1'b0);
  endtask

  initial begin
    logic [7:0] c, a, p;
    repeat (3) @(negedge clk);
    chk("R10 pec", pec, 8'h00);
    chk("R10 verdict", {vv, vp}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    put(8'h5A);
    chk("R10 idle after reset", pec, 8'h00);

    // R1 check value; address 0x31 is a read, eight data bytes follow
    do_start();
    for (int i = 0; i < 9; i++) put(8'h31 + 8'(i));
    chk("R1 check value", pec, 8'hF4);
    stop_expect("R7 read pass", 1'b1);

    // R5 exhaustive command sweep, good and corrupted check byte
    for (int ai = 0; ai < 8; ai++) begin
      for (int ci = 0; ci < 256; ci++) begin
        a = 8'((8'h20 + ai) << 1);
        c = 8'(ci);
        p = crc_b(crc_b(8'h00, a), c);
        do_start();
        chk("R2 start clears", pec, 8'h00);
        put(a);
        put(c);
        chk("R1 running crc", pec, p);
        put(p);
        stop_expect("R5 good check byte", 1'b1);
        do_start();
        put(a);
        put(c);
        put(p ^ (8'h01 << (ci % 8)));
        stop_expect("R5 bad check byte", 1'b0);
      end
    end

    // R3 / R7 combined write-read sweep
    for (int di = 0; di < 256; di += 3) begin
      p = crc_b(crc_b(8'h00, 8'hA0), 8'h8B);
      do_start();
      put(8'hA0);
      put(8'h8B);
      do_rstart();
      chk("R3 rstart keeps crc", pec, p);
      put(8'hA1);
      p = crc_b(p, 8'hA1);
      put(8'(di));
      p = crc_b(p, 8'(di));
      put(~8'(di));
      p = crc_b(p, ~8'(di));
      chk("R7 append byte", pec, p);
      stop_expect("R7 combined read", 1'b1);
    end

    // R7 read with no data
    do_start(); put(8'hA0); put(8'h01); do_rstart(); put(8'hA1);
    stop_expect("R7 empty read", 1'b0);
    // R6 short writes
    do_start(); put(8'h40);
    stop_expect("R6 address only", 1'b0);
    do_start(); put(8'h40); put(crc_b(8'h00, 8'h40));
    stop_expect("R6 no check byte", 1'b0);
    do_start();
    stop_expect("R6 no address", 1'b0);
    do_start(); put(8'h40); put(8'h11); do_rstart();
    stop_expect("R6 stop before second address", 1'b0);

    // R3 direction from bit 0: same bytes, read then write
    do_start(); put(8'h41); put(8'h33);
    stop_expect("R3 read direction", 1'b1);
    do_start(); put(8'h40); put(8'h33);
    stop_expect("R3 write direction", 1'b0);

    // R8 idle stop, R4 idle bytes
    p = pec;
    drv(0, 0, 1, 0, 8'h00);
    chk("R8 idle stop", vv, 1'b0);
    put(8'hC3); put(8'h3C);
    chk("R4 idle bytes ignored", pec, p);
    do_rstart(); put(8'h77);
    chk("R4 rstart while idle", pec, p);

    // R9 byte with rstart dropped
    do_start(); put(8'h41); put(8'h10);
    p = pec;
    drv(0, 1, 0, 1, 8'h99);
    chk("R9 byte with rstart", pec, p);
    put(8'h41);
    chk("R9 next is address", pec, crc_b(p, 8'h41));
    stop_expect("R9 empty read after rstart", 1'b0);
    // R9 byte with stop dropped
    do_start(); put(8'h40); put(8'h12);
    p = crc_b(crc_b(8'h00, 8'h40), 8'h12);
    put(p);
    drv(0, 0, 1, 1, 8'h77);
    chk("R9 byte with stop", {vv, vp}, 2'b11);
    @(negedge clk);
    // R9 stop beats start
    do_start(); put(8'h40);
    drv(1, 0, 1, 0, 8'h00);
    chk("R9 stop over start verdict", {vv, vp}, 2'b10);
    p = pec;
    put(8'h5A);
    chk("R9 stop over start idle", pec, p);
    // R9 start beats rstart
    do_start(); put(8'h40); put(8'h01);
    drv(1, 1, 0, 0, 8'h00);
    chk("R9 start over rstart", pec, 8'h00);
    stop_expect("R9 start over rstart phase", 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule